// File: doc/BRIEF.md
# Four-Mode Addressable Bit Latch

This block holds a small bank of single-bit storage positions (eight by default). A binary select input names one position and a single data input supplies the value for it. Two active-low controls, an enable and a wipe, choose between four modes: update only the selected bit, freeze every bit, route the data onto the selected bit while zeroing the rest, or zero the whole bank.

The block is a synchronous, clock-sampled design. All inputs are captured on the rising clock edge and the output bus is a register, so it changes only on that edge. A synchronous active-high reset sets every stored bit to zero. Typical uses are bit-addressed working registers, conversion of serial data into parallel data, and active-high one-of-N decoding. Software should keep the enable high while it changes the select, so that no stray position is written during the change.

Top module: `addr_latch_top`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `q_o` is 0 after that edge.
- R2: Write mode (`wipe_n_i`=1, `enable_n_i`=0): after the edge, bit `sel_i` of `q_o` equals `data_i` and every other bit keeps its previous value.
- R3: Hold mode (`wipe_n_i`=1, `enable_n_i`=1): `q_o` is unchanged by the edge whatever `sel_i` and `data_i` are, including while the select changes from cycle to cycle.
- R4: Demux mode (`wipe_n_i`=0, `enable_n_i`=0): after the edge, bit `sel_i` of `q_o` equals `data_i` and every other bit is 0.
- R5: Clear mode (`wipe_n_i`=0, `enable_n_i`=1): after the edge, all bits of `q_o` are 0 whatever `sel_i` and `data_i` are, and they stay 0 through later hold cycles until a write.
- R6: The select is unsigned binary with bit `SEL_W-1` as its MSB: value 0 addresses `q_o[0]` and value 7 addresses `q_o[7]`.
- R7: The demux result is stored. A hold cycle that follows a demux cycle still shows `data_i` on the addressed bit and 0 on all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_i | input | SEL_W (3) | Binary select of one bit position |
| data_i | input | 1 | Value for the selected position |
| enable_n_i | input | 1 | Active-low update enable |
| wipe_n_i | input | 1 | Active-low wipe control |
| q_o | output | WIDTH (8) | Stored bits, active high |

## Verification
Every mode has one register between its inputs and `q_o`. The result of the inputs sampled at edge N is therefore due on `q_o` just after edge N, and it must persist until edge N+1. The driver changes the inputs on the falling edge and enqueues the expected word for the next rising edge. The monitor pops one entry 2 ns after each rising edge and compares it then, so each check sees exactly the result of the inputs set half a cycle earlier.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } latch_mode_e;
endpackage

// File: rtl/addr_latch_mode.sv
module addr_latch_mode
  import addr_latch_pkg::*;
(
  input  logic        enable_n_i,
  input  logic        wipe_n_i,
  output latch_mode_e mode_o
);
  always_comb begin
    unique case ({wipe_n_i, enable_n_i})
      2'b10:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_DEMUX;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/addr_latch_sel.sv
module addr_latch_sel #(
  parameter int WIDTH = 8,
  parameter int SEL_W = $clog2(WIDTH)
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [WIDTH-1:0] hit_o
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_hit
    assign hit_o[k] = (sel_i == SEL_W'(k));
  end
endmodule

// File: rtl/addr_latch_cell.sv
module addr_latch_cell
  import addr_latch_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  latch_mode_e mode_i,
  input  logic        hit_i,
  input  logic        data_i,
  output logic        bit_o
);
  logic nxt;

  always_comb begin
    unique case (mode_i)
      MODE_WRITE: nxt = hit_i ? data_i : bit_o;
      MODE_HOLD:  nxt = bit_o;
      MODE_DEMUX: nxt = hit_i & data_i;
      default:    nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bit_o <= 1'b0;
    else     bit_o <= nxt;
  end
endmodule

// File: rtl/addr_latch_top.sv
module addr_latch_top
  import addr_latch_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SEL_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             data_i,
  input  logic             enable_n_i,
  input  logic             wipe_n_i,
  output logic [WIDTH-1:0] q_o
);
  latch_mode_e      mode;
  logic [WIDTH-1:0] hit;

  addr_latch_mode u_mode (
    .enable_n_i (enable_n_i),
    .wipe_n_i   (wipe_n_i),
    .mode_o     (mode)
  );

  addr_latch_sel #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_sel (
    .sel_i (sel_i),
    .hit_o (hit)
  );

  for (genvar k = 0; k < WIDTH; k++) begin : g_cell
    addr_latch_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .mode_i (mode),
      .hit_i  (hit[k]),
      .data_i (data_i),
      .bit_o  (q_o[k])
    );
  end
endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
  parameter int WIDTH = 8,
  parameter int SEL_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst,
  input logic [SEL_W-1:0] sel_i,
  input logic             data_i,
  input logic             enable_n_i,
  input logic             wipe_n_i,
  input logic [WIDTH-1:0] q_o
);
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (q_o == '0));

  a_r2_write_bit: assert property (@(posedge clk) disable iff (rst)
    (wipe_n_i && !enable_n_i) |=>
      (q_o[$past(sel_i)] == $past(data_i)) &&
      ((q_o & ~(WIDTH'(1) << $past(sel_i))) ==
       ($past(q_o) & ~(WIDTH'(1) << $past(sel_i)))));

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (wipe_n_i && enable_n_i) |=> $stable(q_o));

  a_r4_demux_onehot: assert property (@(posedge clk) disable iff (rst)
    (!wipe_n_i && !enable_n_i) |=>
      (q_o == (WIDTH'($past(data_i)) << $past(sel_i))) && $onehot0(q_o));

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (!wipe_n_i && enable_n_i) |=> (q_o == '0));
endmodule

bind addr_latch_top addr_latch_chk #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_i      (sel_i),
  .data_i     (data_i),
  .enable_n_i (enable_n_i),
  .wipe_n_i   (wipe_n_i),
  .q_o        (q_o)
);

// File: tb/test_addr_latch_top.sv
module test_addr_latch_top;
  localparam int WIDTH = 8;
  localparam int SEL_W = 3;

  typedef struct {
    logic [WIDTH-1:0] q;
    string            req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [SEL_W-1:0] sel_i = '0;
  logic             data_i = 1'b0;
  logic             enable_n_i = 1'b1;
  logic             wipe_n_i = 1'b1;
  logic [WIDTH-1:0] q_o;

  exp_t             sb[$];
  logic [WIDTH-1:0] model = '0;
  int               n_run = 0;
  int               n_fail = 0;
  bit               done = 1'b0;

  always #5 clk = ~clk;

  addr_latch_top #(.WIDTH(WIDTH), .SEL_W(SEL_W)) i_addr_latch_top (
    .clk(clk), .rst(rst), .sel_i(sel_i), .data_i(data_i),
    .enable_n_i(enable_n_i), .wipe_n_i(wipe_n_i), .q_o(q_o)
  );

  // Driver: sets inputs on the falling edge, predicts the word after the next rising edge
  task automatic drive(input logic r, input logic wn, input logic en,
                       input int s, input logic d, input string req);
    exp_t e;
    @(negedge clk);
    rst = r; wipe_n_i = wn; enable_n_i = en; sel_i = SEL_W'(s); data_i = d;
    if (r)              model = '0;
    else if (wn && !en) model[s] = d;
    else if (!wn && !en) model = WIDTH'(d) << s;
    else if (!wn && en) model = '0;
    e.q = model; e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: compares one expected word 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (q_o !== e.q) begin
        n_fail++;
        $display("FAIL %s: q_o=%b expected %b", e.req, q_o, e.q);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    drive(1, 1, 1, 0, 0, "R1");
    drive(1, 1, 0, 5, 1, "R1");
    // R2, R6: write a one at each address in turn, then zero some back
    for (int a = 0; a < WIDTH; a++) drive(0, 1, 0, a, 1, "R2_R6");
    drive(0, 1, 0, 3, 0, "R2");
    drive(0, 1, 0, 7, 0, "R2_R6");
    drive(0, 1, 0, 0, 0, "R2_R6");
    // R3: hold while the select and data move
    for (int a = 0; a < WIDTH; a++) drive(0, 1, 1, WIDTH - 1 - a, a[0], "R3");
    // R4, R7: demux on each address with both data values, then hold
    for (int a = 0; a < WIDTH; a++) begin
      drive(0, 0, 0, a, 1, "R4");
      drive(0, 1, 1, (a + 3) % WIDTH, 0, "R7");
      drive(0, 0, 0, a, 0, "R4");
    end
    drive(0, 0, 0, 6, 1, "R4");
    drive(0, 1, 1, 1, 1, "R7");
    // R5: clear with varied select and data, then holds stay zero
    drive(0, 1, 0, 2, 1, "R2");
    drive(0, 0, 1, 2, 1, "R5");
    drive(0, 1, 1, 4, 1, "R5");
    drive(0, 1, 1, 7, 0, "R5");
    drive(0, 0, 1, 5, 0, "R5");
    drive(0, 1, 0, 4, 1, "R2");
    // Mixed sequence across all modes
    for (int i = 0; i < 200; i++) begin
      int unsigned r;
      r = $urandom;
      drive(0, r[4] | r[5], r[6], int'(r[2:0]), r[3], "R2_R3_R4_R5");
    end
    // R1: reset mid-run
    drive(1, 1, 0, 1, 1, "R1");
    drive(0, 1, 1, 1, 1, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule